// File: doc/BRIEF.md
# Byte Slot Interchange with Paged Connection Map

This block switches single bytes between time slots of a byte-serial stream. The stream is divided into frames of `SLOTS` byte slots; at full rate a frame holds 9720 slots and lasts 125 µs at 77.76 MHz. A frame pulse marks slot 0. Each incoming byte is stored, in slot order, into one of two frame banks. Each outgoing slot reads the byte that its connection-map entry names from the bank that holds the previous frame. Any input slot can therefore reach any output slot, with a latency of exactly one frame.

The connection map is held in two pages, and only one page is active at a time. Configuration writes go to the inactive page. A swap request is latched, and the active page flips only on the next frame boundary, so no frame is ever switched with a mix of two maps.

Top module: `slot_xchg`

## Requirements
- R1: The slot index is forced to 0 in any cycle with `frame_in` high. Otherwise it advances by one per clock and wraps from `SLOTS-1` to 0. A cycle at slot 0 is a frame boundary, and `frame_out` is high exactly one clock after each frame boundary.
- R2: When slot t of frame k+1 is presented, `dout` in the following clock equals the byte that arrived in slot m of frame k, where m is the active page's map entry for t.
- R3: After reset, both map pages send every slot to itself (entry t holds t).
- R4: `dout` is zero whenever the previous frame was not stored completely through slot `SLOTS-1`. This covers the first frame after reset and any frame cut short by an early `frame_in`.
- R5: A pulse on `swap_req` sets `swap_pending` one clock later. On the next frame boundary, `active_page` inverts and `swap_pending` clears, unless a new request arrives in that same cycle. `active_page` never changes at any other time.
- R6: A configuration write whose `cfg_page` equals the page in use in that cycle (the new page on a flipping boundary) leaves the map unchanged, and `cfg_err` is high for one clock after it. Otherwise `cfg_err` is low.
- R7: A write to the inactive page stores `cfg_sel` at entry `cfg_addr`. The new entry steers the output once that page becomes active.
- R8: While reset is applied, `dout` is 0 and `frame_out`, `cfg_err`, `swap_pending` and `active_page` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_in | input | 1 | Marks the incoming byte as slot 0 |
| din | input | DW | Incoming byte |
| cfg_we | input | 1 | Map entry write strobe |
| cfg_page | input | 1 | Page the write targets |
| cfg_addr | input | AW | Output slot whose entry is written |
| cfg_sel | input | AW | Input slot that the output slot takes |
| swap_req | input | 1 | Request to exchange active and inactive pages |
| dout | output | DW | Switched byte, registered |
| frame_out | output | 1 | Marks `dout` as output slot 0 |
| active_page | output | 1 | Page currently steering the output |
| swap_pending | output | 1 | Swap requested and not yet taken |
| cfg_err | output | 1 | Previous-cycle write hit the active page |

## Verification
The bench builds the block with `SLOTS = 12` and `DW = 8`, so each frame lasts twelve clocks. This makes it practical to run many frames, to rewrite a whole page, to cut frames short, to let the counter wrap with no pulse, and to place a swap request in the boundary cycle itself. A behavioural model that keeps the stored frame in a queue predicts every output on every clock, so map reversals and rotations check the any-to-any path slot by slot.

// File: rtl/slot_xchg_pkg.sv
package slot_xchg_pkg;

  // Slot index that follows cur in a frame of n slots.
  function automatic int wrap_next(int cur, int n);
    return (cur >= n - 1) ? 0 : cur + 1;
  endfunction

  // Page that steers the current slot, given the stored page, a pending swap
  // and whether this slot opens a frame.
  function automatic logic page_in_use(logic act, logic pend, logic at_boundary);
    return (at_boundary && pend) ? ~act : act;
  endfunction

endpackage

// File: rtl/sx_slot_timer.sv
module sx_slot_timer #(
  parameter int SLOTS = 540,
  parameter int AW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_in,
  output logic [AW-1:0] slot,
  output logic          frame_start,
  output logic          wr_bank
);
  logic [AW-1:0] cnt_q;
  logic          bank_q;

  assign slot        = frame_in ? '0 : cnt_q;
  assign frame_start = (slot == '0);
  assign wr_bank     = frame_start ? ~bank_q : bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bank_q <= 1'b1;
    end else begin
      cnt_q  <= AW'(slot_xchg_pkg::wrap_next(int'(slot), SLOTS));
      bank_q <= wr_bank;
    end
  end
endmodule

// File: rtl/sx_map_pages.sv
module sx_map_pages #(
  parameter int SLOTS = 540,
  parameter int AW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic [AW-1:0] slot,
  input  logic          swap_req,
  input  logic          cfg_we,
  input  logic          cfg_page,
  input  logic [AW-1:0] cfg_addr,
  input  logic [AW-1:0] cfg_sel,
  output logic [AW-1:0] sel,
  output logic          page_now,
  output logic          reject,
  output logic          active_q,
  output logic          pending_q
);
  logic [AW-1:0] pages [2][SLOTS];

  assign page_now = slot_xchg_pkg::page_in_use(active_q, pending_q, frame_start);
  assign reject   = cfg_we && (cfg_page == page_now);
  assign sel      = pages[page_now][slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      pending_q <= 1'b0;
    end else begin
      active_q  <= page_now;
      pending_q <= swap_req || (pending_q && !frame_start);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++)
        for (int i = 0; i < SLOTS; i++)
          pages[p][i] <= AW'(i);
    end else if (cfg_we && !reject && int'(cfg_addr) < SLOTS) begin
      pages[cfg_page][cfg_addr] <= cfg_sel;
    end
  end
endmodule

// File: rtl/sx_frame_store.sv
module sx_frame_store #(
  parameter int SLOTS = 540,
  parameter int DW    = 8,
  parameter int AW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_bank,
  input  logic          frame_start,
  input  logic [AW-1:0] slot,
  input  logic [DW-1:0] din,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_byte,
  output logic          rd_filled
);
  localparam logic [AW-1:0] LAST = AW'(SLOTS - 1);

  logic [DW-1:0] bank_mem [2][SLOTS];
  logic [1:0]    filled_q;
  logic          rd_bank;

  assign rd_bank   = ~wr_bank;
  assign rd_filled = filled_q[rd_bank];
  assign rd_byte   = (rd_filled && int'(rd_addr) < SLOTS) ? bank_mem[rd_bank][rd_addr] : '0;

  always_ff @(posedge clk) begin
    bank_mem[wr_bank][slot] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filled_q <= '0;
    end else if (slot == LAST) begin
      filled_q[wr_bank] <= 1'b1;
    end else if (frame_start) begin
      filled_q[wr_bank] <= 1'b0;
    end
  end
endmodule

// File: rtl/slot_xchg.sv
module slot_xchg #(
  parameter int SLOTS = 540,
  parameter int DW    = 8,
  parameter int AW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_in,
  input  logic [DW-1:0] din,
  input  logic          cfg_we,
  input  logic          cfg_page,
  input  logic [AW-1:0] cfg_addr,
  input  logic [AW-1:0] cfg_sel,
  input  logic          swap_req,
  output logic [DW-1:0] dout,
  output logic          frame_out,
  output logic          active_page,
  output logic          swap_pending,
  output logic          cfg_err
);
  // Named internal events, also watched by the checker.
  logic [AW-1:0] slot;
  logic          frame_start;
  logic          wr_bank;
  logic [AW-1:0] map_sel;
  logic          page_now;
  logic          reject;
  logic [DW-1:0] rd_byte;
  logic          rd_filled;

  sx_slot_timer #(.SLOTS(SLOTS), .AW(AW)) u_timer (
    .clk(clk), .rst_n(rst_n), .frame_in(frame_in),
    .slot(slot), .frame_start(frame_start), .wr_bank(wr_bank)
  );

  sx_map_pages #(.SLOTS(SLOTS), .AW(AW)) u_map (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .slot(slot),
    .swap_req(swap_req), .cfg_we(cfg_we), .cfg_page(cfg_page),
    .cfg_addr(cfg_addr), .cfg_sel(cfg_sel), .sel(map_sel),
    .page_now(page_now), .reject(reject),
    .active_q(active_page), .pending_q(swap_pending)
  );

  sx_frame_store #(.SLOTS(SLOTS), .DW(DW), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_bank(wr_bank), .frame_start(frame_start),
    .slot(slot), .din(din), .rd_addr(map_sel),
    .rd_byte(rd_byte), .rd_filled(rd_filled)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout      <= '0;
      frame_out <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      dout      <= rd_byte;
      frame_out <= frame_start;
      cfg_err   <= reject;
    end
  end
endmodule

// File: rtl/sx_checker.sv
module sx_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_in,
  input logic          frame_start,
  input logic          frame_out,
  input logic          swap_req,
  input logic          swap_pending,
  input logic          active_page,
  input logic          page_now,
  input logic          cfg_we,
  input logic          cfg_page,
  input logic          cfg_err,
  input logic          rd_filled,
  input logic [DW-1:0] dout
);
  AST_PULSE_MARKS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_in |=> frame_out); // R1

  AST_BOUNDARY_MARKS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> frame_out); // R1

  AST_ZERO_WHEN_UNFILLED: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_filled |=> (dout == '0)); // R4

  AST_REQUEST_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    swap_req |=> swap_pending); // R5

  AST_FLIP_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && swap_pending) |=> (active_page != $past(active_page))); // R5

  AST_PENDING_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && swap_pending && !swap_req) |=> !swap_pending); // R5

  AST_PAGE_HOLDS_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(active_page)); // R5

  AST_ACTIVE_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_page == page_now) |=> cfg_err); // R6

  AST_NO_SPURIOUS_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> !cfg_err); // R6
endmodule

bind slot_xchg sx_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_in(frame_in), .frame_start(frame_start),
  .frame_out(frame_out), .swap_req(swap_req), .swap_pending(swap_pending),
  .active_page(active_page), .page_now(page_now), .cfg_we(cfg_we),
  .cfg_page(cfg_page), .cfg_err(cfg_err), .rd_filled(rd_filled), .dout(dout)
);

// File: tb/sim_slot_xchg.sv
`timescale 1ns/1ps
module sim_slot_xchg;
  localparam int N  = 12;
  localparam int DW = 8;
  localparam int AW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_in = 1'b0;
  logic [DW-1:0] din = '0;
  logic          cfg_we = 1'b0;
  logic          cfg_page = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [AW-1:0] cfg_sel = '0;
  logic          swap_req = 1'b0;
  logic [DW-1:0] dout;
  logic          frame_out, active_page, swap_pending, cfg_err;

  always #4 clk = ~clk;

  slot_xchg #(.SLOTS(N), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_in(frame_in), .din(din),
    .cfg_we(cfg_we), .cfg_page(cfg_page), .cfg_addr(cfg_addr), .cfg_sel(cfg_sel),
    .swap_req(swap_req), .dout(dout), .frame_out(frame_out),
    .active_page(active_page), .swap_pending(swap_pending), .cfg_err(cfg_err)
  );

  // Behavioural reference state.
  int         compared = 0;
  int         mismatched = 0;
  bit         finished = 0;
  int         pos = 0;
  byte        now_q[$];
  byte        last_frame[N];
  bit         last_ok = 0;
  int         route[2][N];
  bit         act = 0, pend = 0;
  int         e_dout;
  bit         e_fo, e_err;
  string      dtag = "R3";
  int         seed = 7;

  task automatic check(bit ok, string tag, int actual, int expect_v);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, actual, expect_v, $time);
    end
  endtask

  // Predict outputs of the coming edge from the inputs now applied.
  task automatic predict();
    int  s;
    bit  boundary;
    bit  pg;
    s        = frame_in ? 0 : pos;
    boundary = (s == 0);
    if (boundary) begin
      if (now_q.size() == N) begin
        foreach (last_frame[i]) last_frame[i] = now_q[i];
        last_ok = 1;
      end else begin
        last_ok = 0;
      end
      now_q.delete();
    end
    pg     = (boundary && pend) ? !act : act;
    e_dout = last_ok ? int'(last_frame[route[pg][s]]) & 8'hFF : 0;
    e_err  = cfg_we && (cfg_page == pg);
    if (cfg_we && !e_err) route[cfg_page][cfg_addr] = int'(cfg_sel);
    act  = pg;
    pend = swap_req || (pend && !boundary);
    now_q.push_back(byte'(din));
    pos  = (s + 1) % N;
    e_fo = boundary;
  endtask

  task automatic tick(bit f, bit we = 0, bit pgsel = 0, int a = 0, int sl = 0, bit sw = 0);
    seed     = (seed * 73 + 41) % 251;
    frame_in = f;
    din      = DW'(seed);
    cfg_we   = we;
    cfg_page = pgsel;
    cfg_addr = AW'(a);
    cfg_sel  = AW'(sl);
    swap_req = sw;
    predict();
    @(posedge clk);
    @(negedge clk);
    check(int'(dout) == e_dout, dtag, int'(dout), e_dout);
    check(frame_out == e_fo, "R1", int'(frame_out), int'(e_fo));
    check(cfg_err == e_err, "R6", int'(cfg_err), int'(e_err));
    check(active_page == act, "R5", int'(active_page), int'(act));
    check(swap_pending == pend, "R5", int'(swap_pending), int'(pend));
  endtask

  task automatic frames(int count);
    for (int k = 0; k < count * N; k++) tick(k % N == 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < N; i++) route[p][i] = i;
    repeat (3) @(negedge clk);
    // R8: outputs during reset.
    check(dout == '0, "R8", int'(dout), 0);
    check(!frame_out && !cfg_err, "R8", int'(frame_out | cfg_err), 0);
    check(!active_page && !swap_pending, "R8", int'(active_page | swap_pending), 0);
    rst_n = 1'b1;

    // R4 for first frame, then R3 identity mapping through R2 path.
    dtag = "R3";
    frames(3);

    // R7: reverse map into inactive page 1; R6: a write into active page 0.
    dtag = "R7";
    for (int i = 0; i < N; i++) tick(i == 0, 1, 1, i, N - 1 - i);
    tick(0, 1, 0, 3, 9);                      // R6 rejected
    for (int i = 2; i < N; i++) tick(0, 0, 0, 0, 0, i == 5); // R5 request mid frame
    frames(3);

    // R6: page 1 now active; write there is rejected. Rotate page 0, swap back.
    dtag = "R2";
    tick(1, 1, 1, 0, 5);
    for (int i = 1; i < N; i++) tick(0, 1, 0, i, (i + 3) % N);
    tick(1, 1, 0, 0, 3, 1);                   // R5 request on the boundary itself
    for (int i = 1; i < N; i++) tick(0);
    frames(2);

    // R4: frame cut short by an early pulse gives a zero frame afterwards.
    dtag = "R4";
    for (int i = 0; i < 5; i++) tick(i == 0);
    frames(3);

    // R1: free-running wrap without pulses, with a swap request pending.
    dtag = "R2";
    tick(0, 0, 0, 0, 0, 1);
    for (int k = 0; k < 3 * N; k++) tick(0);
    finish_run();
  end
endmodule